// File: doc/BRIEF.md
# I2C Master Register and FIFO Front End

This block is the software-facing half of a FIFO-based I2C master. A 32-bit register port with word offsets reaches the controller settings, a command word, interrupt enable and status, and two 64-entry byte queues. Software queues the address byte and any write bytes in the transmit queue, with bit 31 of the last write marking the end of the message. It then writes the command word with the start bit set. A separate transaction engine drives the bus. It drains the transmit queue, pushes received bytes with their per-byte status into the receive queue, and pulses a completion strobe with a 3-bit result code.

The start bit reads as busy for the whole transaction and clears when the engine reports completion. Its falling edge latches the done interrupt. Two further status sources follow the receive queue: one for a fill level above a programmable threshold, and one for a full queue. The interrupt line is high while any enabled status bit is pending.

Top module: `i2c_regfront`

## Requirements
- R1: After reset every register reads zero, both queues are empty, `irq` is low and `bus_rdata` is zero.
- R2: The settings fields read back at their positions, with every other bit reading zero. These are: controller reset at offset 0x00 bit 31, enable at bit 30 and retry count at bits 19:16; fast mode at offset 0x04 bit 31; receive threshold at offset 0x0C bits 13:8; and the enables at offset 0x38 bits 31, 30 and 28. The enable, retry and fast fields also appear on the engine outputs.
- R3: A write to offset 0x40 queues byte bits 7:0 with an end flag taken from bit 31. The engine sees the entries in write order on `eng_tx_data`/`eng_tx_last` while `eng_tx_valid` is high, and `eng_tx_pop` removes the head.
- R4: A transmit write while 64 entries are queued is discarded, and the queue contents are left unchanged.
- R5: `eng_rx_push` queues a received byte. A read of offset 0x44 returns the oldest byte in bits 7:0, its status in bits 31:30 and its check-error flag in bit 29, then removes it. Offset 0x0C bits 22:16 report the receive fill count.
- R6: A read of offset 0x44 with the receive queue empty returns zero and leaves the count at zero.
- R7: Writing 1 to offset 0x0C bit 31 empties the receive queue, and writing 1 to bit 30 empties the transmit queue. Both bits read as zero.
- R8: A command write (offset 0x30) while idle loads bit 31 start, bits 12:9 protocol, bit 8 check enable and bits 7:0 read count, and drives them to the engine. A command write while busy is ignored.
- R9: `eng_done` while busy clears the start bit, stores `eng_result` in command bits 27:25 and sets status bit 28 (offset 0x3C).
- R10: Status bit 30 is set while the receive count exceeds the threshold. Status bit 31 is set while the receive queue is full. Both stay set until cleared.
- R11: Writing 1 to a status bit clears it and writing 0 leaves it. A source still active sets the bit again.
- R12: `irq` is high exactly when some status bit is set and its enable bit is set.
- R13: While the controller reset bit is set, both queues stay empty, the status register stays zero and the start bit stays clear. The settings registers remain writable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; data appears the next cycle |
| bus_addr | input | 8 | Byte offset; bits 7:2 select the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| irq | output | 1 | Interrupt request |
| eng_enable | output | 1 | Controller enable |
| eng_retry | output | 4 | Retry count |
| eng_fast | output | 1 | 400 kHz mode when high |
| eng_start | output | 1 | Start/busy bit |
| eng_proto | output | 4 | Protocol code (7 block write, 8 block read) |
| eng_pec | output | 1 | Packet check enable |
| eng_rd_cnt | output | 8 | Bytes to read |
| eng_done | input | 1 | Transaction complete strobe |
| eng_result | input | 3 | Result code at completion |
| eng_tx_valid | output | 1 | Transmit queue not empty |
| eng_tx_data | output | 8 | Transmit head byte |
| eng_tx_last | output | 1 | Head byte ends the message |
| eng_tx_pop | input | 1 | Remove the transmit head |
| eng_rx_push | input | 1 | Queue a received byte |
| eng_rx_data | input | 8 | Received byte |
| eng_rx_stat | input | 2 | Per-byte status |
| eng_rx_pecerr | input | 1 | Per-byte check-error flag |

## Verification
On every cycle the assertions check four things. The queue counts never pass the depth. A full queue does not grow and an empty one does not underflow. A completion while busy always drops busy and latches the done status. The controller reset keeps status and busy cleared. Only the bench scenarios can show the data content. These are byte order and end flags through both queues, the field packing of the receive word, and the exact read-back encodings. The same holds for how the write-one-to-clear status interacts with the enables on `irq`.

// File: rtl/i2c_regfront_pkg.sv
package i2c_regfront_pkg;
    localparam int WORD_IDX_W = 6;

    localparam logic [WORD_IDX_W-1:0] WI_SETUP  = 6'h00;
    localparam logic [WORD_IDX_W-1:0] WI_SPEED  = 6'h01;
    localparam logic [WORD_IDX_W-1:0] WI_QCTL   = 6'h03;
    localparam logic [WORD_IDX_W-1:0] WI_CMD    = 6'h0C;
    localparam logic [WORD_IDX_W-1:0] WI_IRQEN  = 6'h0E;
    localparam logic [WORD_IDX_W-1:0] WI_IRQST  = 6'h0F;
    localparam logic [WORD_IDX_W-1:0] WI_TXQ    = 6'h10;
    localparam logic [WORD_IDX_W-1:0] WI_RXQ    = 6'h11;

    // index into the compact 3-bit interrupt vector
    localparam int IV_DONE = 0;  // word bit 28
    localparam int IV_THR  = 1;  // word bit 30
    localparam int IV_FULL = 2;  // word bit 31

    localparam int TXQ_W = 9;    // {last, byte}
    localparam int RXQ_W = 11;   // {stat[1:0], pecerr, byte}
endpackage

// File: rtl/i2c_regfront_fifo.sv
module i2c_regfront_fifo #(
    parameter int W     = 9,
    parameter int DEPTH = 64,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic [W-1:0]  rdata,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } qstate_t;

    qstate_t q_q, q_d;
    logic [W-1:0] mem_q [DEPTH];
    logic do_push, do_pop;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (q_q.cnt == CW'(DEPTH));
    assign empty   = (q_q.cnt == '0);
    assign count   = q_q.cnt;
    assign rdata   = mem_q[q_q.rp];
    assign do_push = push & ~full & ~flush;
    assign do_pop  = pop & ~empty & ~flush;

    always_comb begin
        q_d = q_q;
        if (flush) begin
            q_d = '0;
        end else begin
            if (do_push) q_d.wp = bump(q_q.wp);
            if (do_pop)  q_d.rp = bump(q_q.rp);
            case ({do_push, do_pop})
                2'b10:   q_d.cnt = q_q.cnt + 1'b1;
                2'b01:   q_d.cnt = q_q.cnt - 1'b1;
                default: q_d.cnt = q_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[q_q.wp] <= wdata;
    end

    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        q_q.cnt <= CW'(DEPTH));
    assert_full_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !flush) |=> (q_q.cnt == $past(q_q.cnt)));
    assert_empty_pop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push) |=> empty);
    assert_flush_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty);
endmodule

// File: rtl/i2c_regfront_csr.sv
module i2c_regfront_csr
    import i2c_regfront_pkg::*;
#(
    parameter int CW = 7,
    parameter int DEPTH = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [7:0]    bus_addr,
    input  logic [31:0]   bus_wdata,
    output logic [31:0]   bus_rdata,
    output logic          irq,
    output logic          eng_enable,
    output logic [3:0]    eng_retry,
    output logic          eng_fast,
    output logic          eng_start,
    output logic [3:0]    eng_proto,
    output logic          eng_pec,
    output logic [7:0]    eng_rd_cnt,
    input  logic          eng_done,
    input  logic [2:0]    eng_result,
    output logic          txq_push,
    output logic [TXQ_W-1:0] txq_wdata,
    output logic          txq_flush,
    output logic          rxq_pop,
    output logic          rxq_flush,
    input  logic [RXQ_W-1:0] rxq_head,
    input  logic [CW-1:0] rxq_count,
    input  logic          rxq_full,
    input  logic          rxq_empty
);
    typedef struct packed {
        logic        srst;
        logic        en;
        logic [3:0]  retry;
        logic        fast;
        logic [5:0]  thld;
        logic        busy;
        logic [2:0]  result;
        logic [3:0]  proto;
        logic        pec;
        logic [7:0]  rdcnt;
        logic [2:0]  ie;
        logic [2:0]  is;
        logic [31:0] rdata;
    } csr_t;

    csr_t r_q, r_d;
    logic [WORD_IDX_W-1:0] widx;
    logic [31:0] rword;
    logic [2:0]  st_set, st_clr;
    logic        flush_rx_w, flush_tx_w;

    assign widx = bus_addr[7:2];
    wire unused_addr_lsb = ^bus_addr[1:0];

    always_comb begin
        rword = '0;
        case (widx)
            WI_SETUP: begin
                rword[31]    = r_q.srst;
                rword[30]    = r_q.en;
                rword[19:16] = r_q.retry;
            end
            WI_SPEED: rword[31] = r_q.fast;
            WI_QCTL: begin
                rword[16 +: CW] = rxq_count;
                rword[13:8]     = r_q.thld;
            end
            WI_CMD: begin
                rword[31]    = r_q.busy;
                rword[27:25] = r_q.result;
                rword[12:9]  = r_q.proto;
                rword[8]     = r_q.pec;
                rword[7:0]   = r_q.rdcnt;
            end
            WI_IRQEN: begin
                rword[31] = r_q.ie[IV_FULL];
                rword[30] = r_q.ie[IV_THR];
                rword[28] = r_q.ie[IV_DONE];
            end
            WI_IRQST: begin
                rword[31] = r_q.is[IV_FULL];
                rword[30] = r_q.is[IV_THR];
                rword[28] = r_q.is[IV_DONE];
            end
            WI_RXQ: begin
                if (!rxq_empty) begin
                    rword[31:30] = rxq_head[10:9];
                    rword[29]    = rxq_head[8];
                    rword[7:0]   = rxq_head[7:0];
                end
            end
            default: rword = '0;
        endcase
    end

    always_comb begin
        r_d        = r_q;
        st_set     = '0;
        st_clr     = '0;
        flush_rx_w = 1'b0;
        flush_tx_w = 1'b0;
        txq_push   = 1'b0;
        txq_wdata  = {bus_wdata[31], bus_wdata[7:0]};
        rxq_pop    = 1'b0;

        if (bus_wr) begin
            case (widx)
                WI_SETUP: begin
                    r_d.srst  = bus_wdata[31];
                    r_d.en    = bus_wdata[30];
                    r_d.retry = bus_wdata[19:16];
                end
                WI_SPEED: r_d.fast = bus_wdata[31];
                WI_QCTL: begin
                    flush_rx_w = bus_wdata[31];
                    flush_tx_w = bus_wdata[30];
                    r_d.thld   = bus_wdata[13:8];
                end
                WI_CMD: begin
                    if (!r_q.busy && !r_q.srst) begin
                        r_d.busy  = bus_wdata[31];
                        r_d.proto = bus_wdata[12:9];
                        r_d.pec   = bus_wdata[8];
                        r_d.rdcnt = bus_wdata[7:0];
                    end
                end
                WI_IRQEN: r_d.ie = {bus_wdata[31], bus_wdata[30], bus_wdata[28]};
                WI_IRQST: st_clr = {bus_wdata[31], bus_wdata[30], bus_wdata[28]};
                WI_TXQ:   txq_push = 1'b1;
                default: ;
            endcase
        end

        if (r_q.busy && eng_done) begin
            r_d.busy        = 1'b0;
            r_d.result      = eng_result;
            st_set[IV_DONE] = 1'b1;
        end
        st_set[IV_THR]  = int'(rxq_count) > int'(r_q.thld);
        st_set[IV_FULL] = rxq_full;
        r_d.is = (r_q.is & ~st_clr) | st_set;

        if (bus_rd) begin
            r_d.rdata = rword;
            if (widx == WI_RXQ && !rxq_empty) rxq_pop = 1'b1;
        end

        if (r_q.srst) begin
            r_d.is   = '0;
            r_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign txq_flush  = flush_tx_w | r_q.srst;
    assign rxq_flush  = flush_rx_w | r_q.srst;
    assign bus_rdata  = r_q.rdata;
    assign irq        = |(r_q.is & r_q.ie);
    assign eng_enable = r_q.en;
    assign eng_retry  = r_q.retry;
    assign eng_fast   = r_q.fast;
    assign eng_start  = r_q.busy;
    assign eng_proto  = r_q.proto;
    assign eng_pec    = r_q.pec;
    assign eng_rd_cnt = r_q.rdcnt;

    assert_done_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.busy && eng_done && !r_q.srst) |=> (!r_q.busy && r_q.is[IV_DONE]));
    assert_start_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && widx == WI_CMD && bus_wdata[31] && !r_q.busy && !r_q.srst)
        |=> r_q.busy);
    assert_busy_locks_cmd_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.busy && !eng_done) |=> ($stable(r_q.proto) && $stable(r_q.rdcnt)));
    assert_srst_holds_R13: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.srst |=> (r_q.is == '0 && !r_q.busy));
    assert_full_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rxq_full && !r_q.srst) |=> r_q.is[IV_FULL]);
endmodule

// File: rtl/i2c_regfront.sv
module i2c_regfront
    import i2c_regfront_pkg::*;
#(
    parameter int QDEPTH = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq,
    output logic        eng_enable,
    output logic [3:0]  eng_retry,
    output logic        eng_fast,
    output logic        eng_start,
    output logic [3:0]  eng_proto,
    output logic        eng_pec,
    output logic [7:0]  eng_rd_cnt,
    input  logic        eng_done,
    input  logic [2:0]  eng_result,
    output logic        eng_tx_valid,
    output logic [7:0]  eng_tx_data,
    output logic        eng_tx_last,
    input  logic        eng_tx_pop,
    input  logic        eng_rx_push,
    input  logic [7:0]  eng_rx_data,
    input  logic [1:0]  eng_rx_stat,
    input  logic        eng_rx_pecerr
);
    localparam int CW = $clog2(QDEPTH + 1);

    logic             txq_push, txq_flush, rxq_pop, rxq_flush;
    logic [TXQ_W-1:0] txq_wdata, txq_head;
    logic [RXQ_W-1:0] rxq_head;
    logic [CW-1:0]    txq_count, rxq_count;
    logic             txq_full, txq_empty, rxq_full, rxq_empty;

    i2c_regfront_csr #(.CW(CW), .DEPTH(QDEPTH)) u_csr (
        .clk, .rst_n, .bus_wr, .bus_rd, .bus_addr, .bus_wdata, .bus_rdata, .irq,
        .eng_enable, .eng_retry, .eng_fast, .eng_start, .eng_proto, .eng_pec,
        .eng_rd_cnt, .eng_done, .eng_result,
        .txq_push, .txq_wdata, .txq_flush, .rxq_pop, .rxq_flush,
        .rxq_head, .rxq_count, .rxq_full, .rxq_empty
    );

    i2c_regfront_fifo #(.W(TXQ_W), .DEPTH(QDEPTH)) u_txq (
        .clk, .rst_n, .flush(txq_flush), .push(txq_push), .wdata(txq_wdata),
        .pop(eng_tx_pop), .rdata(txq_head), .count(txq_count),
        .full(txq_full), .empty(txq_empty)
    );

    i2c_regfront_fifo #(.W(RXQ_W), .DEPTH(QDEPTH)) u_rxq (
        .clk, .rst_n, .flush(rxq_flush), .push(eng_rx_push),
        .wdata({eng_rx_stat, eng_rx_pecerr, eng_rx_data}),
        .pop(rxq_pop), .rdata(rxq_head), .count(rxq_count),
        .full(rxq_full), .empty(rxq_empty)
    );

    wire unused_txq = ^{txq_count, txq_full};

    assign eng_tx_valid = ~txq_empty;
    assign eng_tx_data  = txq_head[7:0];
    assign eng_tx_last  = txq_head[8];
endmodule

// File: tb/i2c_regfront_tb.sv
`timescale 1ns/1ps
module i2c_regfront_tb;
    logic        clk = 0, rst_n = 0;
    logic        bus_wr = 0, bus_rd = 0;
    logic [7:0]  bus_addr = 0;
    logic [31:0] bus_wdata = 0, bus_rdata;
    logic        irq, eng_enable, eng_fast, eng_start, eng_pec;
    logic [3:0]  eng_retry, eng_proto;
    logic [7:0]  eng_rd_cnt, eng_tx_data;
    logic        eng_done = 0;
    logic [2:0]  eng_result = 0;
    logic        eng_tx_valid, eng_tx_last;
    logic        eng_tx_pop = 0, eng_rx_push = 0, eng_rx_pecerr = 0;
    logic [7:0]  eng_rx_data = 0;
    logic [1:0]  eng_rx_stat = 0;

    int nchk = 0, nfail = 0;
    logic [31:0] rv;

    always #2 clk = ~clk;

    i2c_regfront u_dut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk); bus_rd = 1; bus_addr = a;
        @(negedge clk); bus_rd = 0; d = bus_rdata;
    endtask

    task automatic rxpush(input logic [7:0] b, input logic [1:0] s, input logic p);
        @(negedge clk); eng_rx_push = 1; eng_rx_data = b; eng_rx_stat = s; eng_rx_pecerr = p;
        @(negedge clk); eng_rx_push = 0;
    endtask

    task automatic done(input logic [2:0] res);
        @(negedge clk); eng_done = 1; eng_result = res;
        @(negedge clk); eng_done = 0;
    endtask

    function automatic logic [31:0] rxword(input int i);
        logic [7:0] b = 8'((i * 11 + 5) & 255);
        logic [1:0] s = 2'(i % 4);
        logic       p = 1'((i / 3) % 2);
        return {s, p, 21'b0, b};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        foreach (rv[i]) ; // no-op keeps rv declared use simple
        begin
            logic [7:0] offs [8] = '{8'h00, 8'h04, 8'h0C, 8'h30, 8'h38, 8'h3C, 8'h40, 8'h44};
            for (int k = 0; k < 8; k++) begin
                rd(offs[k], rv); chk("R1 reg", rv, 32'h0);
            end
        end
        chk("R1 irq", {31'b0, irq}, 0);
        chk("R1 txvalid", {31'b0, eng_tx_valid}, 0);

        // R2 settings readback
        wr(8'h00, 32'h7FFF_FFFF); rd(8'h00, rv); chk("R2 cfg", rv, 32'h400F_0000);
        chk("R2 eng cfg", {26'b0, eng_enable, eng_retry, 1'b0}, {26'b0, 1'b1, 4'hF, 1'b0});
        wr(8'h04, 32'hFFFF_FFFF); rd(8'h04, rv); chk("R2 timing", rv, 32'h8000_0000);
        chk("R2 fast", {31'b0, eng_fast}, 1);
        wr(8'h38, 32'hFFFF_FFFF); rd(8'h38, rv); chk("R2 ie", rv, 32'hD000_0000);
        wr(8'h38, 32'h0);
        wr(8'h0C, 32'h0000_FFFF); rd(8'h0C, rv); chk("R2 thld", rv, 32'h0000_3F00);

        // R3/R4 transmit order, end flag, overflow drop
        for (int i = 0; i < 65; i++)
            wr(8'h40, {(i == 63), 23'b0, 8'((i * 7 + 3) & 255)});
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            chk("R3 tx entry", {22'b0, eng_tx_valid, eng_tx_last, eng_tx_data},
                {22'b0, 1'b1, (i == 63), 8'((i * 7 + 3) & 255)});
            eng_tx_pop = 1; @(negedge clk); eng_tx_pop = 0;
        end
        @(negedge clk);
        chk("R4 65th write dropped", {31'b0, eng_tx_valid}, 0);

        // R10 threshold and full, R5 receive packing
        wr(8'h0C, 32'h0000_0500);
        for (int i = 0; i < 5; i++) rxpush(rxword(i)[7:0], rxword(i)[31:30], rxword(i)[29]);
        @(negedge clk);
        rd(8'h3C, rv); chk("R10 at threshold", rv, 32'h0);
        rxpush(rxword(5)[7:0], rxword(5)[31:30], rxword(5)[29]);
        @(negedge clk);
        rd(8'h3C, rv); chk("R10 above threshold", rv, 32'h4000_0000);
        for (int i = 6; i < 66; i++) rxpush(rxword(i)[7:0], rxword(i)[31:30], rxword(i)[29]);
        @(negedge clk);
        rd(8'h3C, rv); chk("R10 full", rv, 32'hC000_0000);
        rd(8'h0C, rv); chk("R5 rx count", rv, 32'h0040_0500);
        for (int i = 0; i < 64; i++) begin
            rd(8'h44, rv); chk("R5 rx word", rv, rxword(i));
        end
        rd(8'h0C, rv); chk("R5 count drained", rv, 32'h0000_0500);

        // R6 empty read
        rd(8'h44, rv); chk("R6 empty read", rv, 32'h0);
        rd(8'h0C, rv); chk("R6 count stays", rv, 32'h0000_0500);
        rxpush(8'hA5, 2'b10, 1'b1);
        rd(8'h44, rv); chk("R6 no phantom pop", rv, 32'hA000_00A5);

        // R11 write-one-to-clear
        rd(8'h3C, rv); chk("R11 sticky", rv, 32'hC000_0000);
        wr(8'h3C, 32'h4000_0000); rd(8'h3C, rv); chk("R11 clear one", rv, 32'h8000_0000);
        wr(8'h3C, 32'h0000_0000); rd(8'h3C, rv); chk("R11 zero write", rv, 32'h8000_0000);
        wr(8'h3C, 32'hFFFF_FFFF); rd(8'h3C, rv); chk("R11 clear all", rv, 32'h0);

        // R7 flush
        for (int i = 0; i < 3; i++) rxpush(8'(i), 2'b00, 1'b0);
        wr(8'h40, 32'h11); wr(8'h40, 32'h8000_0022);
        wr(8'h0C, 32'hC000_0500);
        rd(8'h0C, rv); chk("R7 flush rx, bits read 0", rv, 32'h0000_0500);
        chk("R7 flush tx", {31'b0, eng_tx_valid}, 0);

        // R8 command
        wr(8'h30, 32'h8000_1121);
        chk("R8 engine fields", {15'b0, eng_start, eng_proto, eng_pec, eng_rd_cnt},
            {15'b0, 1'b1, 4'h8, 1'b1, 8'h21});
        wr(8'h30, 32'h0000_0E00); rd(8'h30, rv); chk("R8 busy write ignored", rv, 32'h8000_1121);

        // R9/R12 completion and interrupt
        wr(8'h38, 32'h1000_0000);
        done(3'd3);
        rd(8'h30, rv); chk("R9 cmd after done", rv, 32'h0600_1121);
        rd(8'h3C, rv); chk("R9 done status", rv, 32'h1000_0000);
        chk("R12 irq enabled", {31'b0, irq}, 1);
        wr(8'h3C, 32'h1000_0000);
        chk("R12 irq cleared", {31'b0, irq}, 0);
        wr(8'h38, 32'h0);
        wr(8'h30, 32'h8000_0E00); done(3'd0);
        rd(8'h3C, rv); chk("R9 second done", rv, 32'h1000_0000);
        chk("R12 irq masked", {31'b0, irq}, 0);
        wr(8'h38, 32'h1000_0000);
        chk("R12 irq unmasked", {31'b0, irq}, 1);
        wr(8'h3C, 32'hFFFF_FFFF);

        // R13 soft reset
        rxpush(8'h01, 2'b00, 1'b0); rxpush(8'h02, 2'b00, 1'b0);
        wr(8'h00, 32'h8000_0000);
        rxpush(8'h03, 2'b00, 1'b0);
        wr(8'h40, 32'h55);
        wr(8'h30, 32'h8000_0E00);
        chk("R13 start blocked", {31'b0, eng_start}, 0);
        chk("R13 tx held empty", {31'b0, eng_tx_valid}, 0);
        wr(8'h0C, 32'h0000_0200);
        rd(8'h0C, rv); chk("R13 rx held empty, thld writable", rv, 32'h0000_0200);
        rd(8'h3C, rv); chk("R13 status held", rv, 32'h0);
        wr(8'h00, 32'h0);
        rd(8'h44, rv); chk("R13 nothing kept", rv, 32'h0);

        $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    end
endmodule